// File: doc/BRIEF.md
# Hash Accelerator Control Register Front End

This block is the software-facing register file of a hash accelerator. A processor reaches it over a simple 32-bit register bus with a select, a write enable, a byte offset and write data. Read data comes back one cycle after the request, qualified by a valid strobe. The block stores the pointers and length that the hash datapath consumes. Each register drops the bits the hardware cannot use: addresses are clipped to a configurable width, digest pointers are forced to 8-byte alignment, and the length is limited to 28 bits.

A write to the command register while the engine is idle launches an operation. The block emits a one-cycle start pulse to the datapath and reports busy. When the datapath returns its done pulse, busy drops and a sticky completion flag rises. Software clears that flag by writing a one to it. An interrupt line follows the interrupt bits of the status word. The algorithm field of the command is decoded into a compact code, and the byte-order and list-mode options are passed straight to the datapath. The implemented address width is a parameter.

Top module: `hash_csr_frontend`

## Requirements
- R1: After reset, every mapped register reads zero, `irq` is low and `hash_start` is low. A zero engine-mode register means direct (non-list) addressing.
- R2: Register byte offsets are: engine mode 0x10 (keeps all 32 bits), status 0x1C, source address 0x20, digest address 0x24, key buffer 0x28, data length 0x2C and command 0x30. Each read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. Any other offset reads zero, and writes to it change nothing.
- R3: The source and key-buffer address registers keep only bits ADDR_W-1:0. With the default ADDR_W of 31, writing 0xFFFFFFFF reads back 0x7FFFFFFF. The stored values drive `hash_src_addr` and `hash_key_addr`.
- R4: The digest address register keeps bits ADDR_W-1:3; its bits 2:0 always read zero. With the default width, writing all ones reads back 0x7FFFFFF8. The value drives `hash_dig_addr`.
- R5: The data length register keeps bits 27:0, so writing all ones reads back 0x0FFFFFFF. It drives `hash_len`.
- R6: The command register keeps only bits 2, 3, 4, 5, 6, 10 and 18 (mask 0x0004047C). Bit 18 drives `hash_sg` (list mode), bit 3 drives `hash_sha_be` and bit 2 drives `hash_md5_le`.
- R7: `hash_algo` decodes command bits {10,6,5,4} as follows. None set gives 0 (MD5). Bit 5 alone gives 1 (SHA-1). Bit 6 alone gives 2 (SHA-224). Bits 6 and 4 give 3 (SHA-256). Bits 10, 6 and 5 give 4 (SHA-384). Bits 6 and 5 give 5 (SHA-512). Any other combination gives 7 (unrecognised).
- R8: A command write while idle is accepted. In the cycle after the write, `hash_start` is high for exactly one cycle, and status bit 0 (busy) reads one from then on.
- R9: A command write while busy is ignored: the command register keeps its value and no start pulse follows.
- R10: A `hash_done` pulse while busy clears status bit 0 and sets status bit 9 (completion) on the next edge. A done pulse while idle changes nothing.
- R11: Writing the status register with bit 9 set clears bit 9. Writing it with bit 9 clear changes nothing. If done and the clear land in the same cycle, bit 9 ends set. Status bits 1, 2, 12 and 13 always read zero.
- R12: `irq` is high exactly when an interrupt bit of the status word (bit 9, 12 or 13) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wen | input | 1 | 1 = write, 0 = read |
| bus_addr | input | OFS_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| hash_start | output | 1 | One-cycle launch pulse to the datapath |
| hash_done | input | 1 | Completion pulse from the datapath |
| hash_src_addr | output | 32 | Clipped source address |
| hash_dig_addr | output | 32 | Clipped, aligned digest address |
| hash_key_addr | output | 32 | Clipped key buffer address |
| hash_len | output | 32 | Clipped data length |
| hash_algo | output | 3 | Decoded algorithm code |
| hash_sg | output | 1 | List (scatter-gather) mode |
| hash_sha_be | output | 1 | Big-endian SHA handling |
| hash_md5_le | output | 1 | Little-endian MD5 handling |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch a set of properties on every cycle:
- the start pulse lasts one cycle and always follows an accepted command;
- commands that arrive while busy never launch;
- a done pulse always leaves the completion flag set and busy clear;
- a clear that does not collide with done empties the flag;
- unmapped offsets return zero;
- the address and length outputs never carry clipped or alignment bits.

Other behaviours only show up in the bench scenarios. These are the exact read-back values after all-ones writes, the full algorithm decode table, and the same-cycle collisions of done with a clear or with a command. The bench's behavioural model checks every output against its prediction each cycle.

// File: rtl/hash_csr_pkg.sv
package hash_csr_pkg;

   localparam int unsigned REG_W = 32;

   // register byte offsets (software map)
   localparam logic [7:0] OFS_MODE = 8'h10;
   localparam logic [7:0] OFS_STAT = 8'h1C;
   localparam logic [7:0] OFS_SRC  = 8'h20;
   localparam logic [7:0] OFS_DIG  = 8'h24;
   localparam logic [7:0] OFS_KEY  = 8'h28;
   localparam logic [7:0] OFS_LEN  = 8'h2C;
   localparam logic [7:0] OFS_CMD  = 8'h30;

   // status word layout
   localparam int unsigned STS_HASH_BUSY = 0;
   localparam int unsigned STS_HASH_IRQ  = 9;
   localparam logic [REG_W-1:0] STS_IRQ_BITS = 32'h0000_3200;

   // command word layout
   localparam int unsigned CMD_MD5_LE = 2;
   localparam int unsigned CMD_SHA_BE = 3;
   localparam int unsigned CMD_SG     = 18;
   localparam logic [REG_W-1:0] CMD_KEEP = 32'h0004_047C;

   typedef enum logic [2:0] {
      ALG_MD5    = 3'd0,
      ALG_SHA1   = 3'd1,
      ALG_SHA224 = 3'd2,
      ALG_SHA256 = 3'd3,
      ALG_SHA384 = 3'd4,
      ALG_SHA512 = 3'd5,
      ALG_BAD    = 3'd7
   } hash_algo_e;

endpackage

// File: rtl/hash_csr_field.sv
module hash_csr_field #(
   parameter int unsigned     W    = 32,
   parameter logic [W-1:0]    KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & KEEP;
   end

endmodule

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
   import hash_csr_pkg::*;
(
   input  logic [3:0]  alg_bits,   // {cmd[10], cmd[6], cmd[5], cmd[4]}
   input  logic        sg_bit,
   input  logic        be_bit,
   input  logic        le_bit,
   output hash_algo_e  algo,
   output logic        sg,
   output logic        sha_be,
   output logic        md5_le
);

   always_comb begin
      unique case (alg_bits)
         4'b0000: algo = ALG_MD5;
         4'b0010: algo = ALG_SHA1;
         4'b0100: algo = ALG_SHA224;
         4'b0101: algo = ALG_SHA256;
         4'b0110: algo = ALG_SHA512;
         4'b1110: algo = ALG_SHA384;
         default: algo = ALG_BAD;
      endcase
   end

   assign sg     = sg_bit;
   assign sha_be = be_bit;
   assign md5_le = le_bit;

endmodule

// File: rtl/hash_csr_status.sv
module hash_csr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr_i,
   input  logic done_i,
   input  logic clr_i,
   output logic take_o,
   output logic start_o,
   output logic busy_o,
   output logic flag_o
);

   logic busy_q, flag_q, start_q;
   logic finish;

   assign take_o = cmd_wr_i & ~busy_q;
   assign finish = done_i & busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         flag_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= take_o;
         if (take_o)      busy_q <= 1'b1;
         else if (finish) busy_q <= 1'b0;
         if (finish)      flag_q <= 1'b1;
         else if (clr_i)  flag_q <= 1'b0;
      end
   end

   assign start_o = start_q;
   assign busy_o  = busy_q;
   assign flag_o  = flag_q;

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);                                   // R8
   AST_TAKE_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (start_q && busy_q));                         // R8
   AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr_i && busy_q) |=> !start_q);                      // R9
   AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && busy_q) |=> (flag_q && !busy_q));             // R10
   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(done_i && busy_q)) |=> !flag_q);             // R11

endmodule

// File: rtl/hash_csr_frontend.sv
module hash_csr_frontend
   import hash_csr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 31,
   parameter int unsigned LEN_W     = 28,
   parameter int unsigned DIG_ALIGN = 3,
   parameter int unsigned OFS_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wen,
   input  logic [OFS_W-1:0] bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic             bus_rvalid,
   output logic [31:0]      bus_rdata,
   output logic             hash_start,
   input  logic             hash_done,
   output logic [31:0]      hash_src_addr,
   output logic [31:0]      hash_dig_addr,
   output logic [31:0]      hash_key_addr,
   output logic [31:0]      hash_len,
   output logic [2:0]       hash_algo,
   output logic             hash_sg,
   output logic             hash_sha_be,
   output logic             hash_md5_le,
   output logic             irq
);

   // ---------------- elaboration checks ----------------
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr_w
      $error("hash_csr_frontend: ADDR_W must lie in 16..32");
   end
   if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len_w
      $error("hash_csr_frontend: LEN_W must lie in 1..32");
   end
   if (DIG_ALIGN > 6) begin : g_bad_align
      $error("hash_csr_frontend: DIG_ALIGN must not exceed 6");
   end
   if (OFS_W < 8) begin : g_bad_ofs_w
      $error("hash_csr_frontend: OFS_W must be at least 8");
   end

   // ---------------- derived masks ----------------
   localparam logic [31:0] ADDR_KEEP = 32'((64'd1 << ADDR_W) - 64'd1);
   localparam logic [31:0] LEN_KEEP  = 32'((64'd1 << LEN_W) - 64'd1);
   localparam logic [31:0] LOW_DROP  = 32'((64'd1 << DIG_ALIGN) - 64'd1);
   localparam logic [31:0] DIG_KEEP  = ADDR_KEEP & ~LOW_DROP;
   localparam int unsigned NFLD      = 5;

   // field index: 0 mode, 1 source, 2 digest, 3 key, 4 length
   function automatic logic [7:0] fld_ofs(input int unsigned idx);
      case (idx)
         0:       return OFS_MODE;
         1:       return OFS_SRC;
         2:       return OFS_DIG;
         3:       return OFS_KEY;
         default: return OFS_LEN;
      endcase
   endfunction

   function automatic logic [31:0] fld_keep(input int unsigned idx);
      case (idx)
         0:       return 32'hFFFF_FFFF;
         1:       return ADDR_KEEP;
         2:       return DIG_KEEP;
         3:       return ADDR_KEEP;
         default: return LEN_KEEP;
      endcase
   endfunction

   // ---------------- bus decode ----------------
   logic wr_en, rd_en;
   logic hit_stat, hit_cmd;
   assign wr_en    = bus_sel &  bus_wen;
   assign rd_en    = bus_sel & ~bus_wen;
   assign hit_stat = (bus_addr == OFS_W'(OFS_STAT));
   assign hit_cmd  = (bus_addr == OFS_W'(OFS_CMD));

   // ---------------- pointer / length / mode fields ----------------
   logic [31:0] fld_q [NFLD];

   for (genvar gi = 0; gi < NFLD; gi++) begin : g_fld
      hash_csr_field #(
         .W    (32),
         .KEEP (fld_keep(gi))
      ) u_fld (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_en && (bus_addr == OFS_W'(fld_ofs(gi)))),
         .wdata (bus_wdata),
         .q     (fld_q[gi])
      );
   end

   assign hash_src_addr = fld_q[1];
   assign hash_dig_addr = fld_q[2];
   assign hash_key_addr = fld_q[3];
   assign hash_len      = fld_q[4];

   // ---------------- launch / completion ----------------
   logic take, busy, flag;

   hash_csr_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr_i (wr_en && hit_cmd),
      .done_i   (hash_done),
      .clr_i    (wr_en && hit_stat && bus_wdata[STS_HASH_IRQ]),
      .take_o   (take),
      .start_o  (hash_start),
      .busy_o   (busy),
      .flag_o   (flag)
   );

   // ---------------- command register ----------------
   logic [31:0] cmd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cmd_q <= '0;
      else if (take) cmd_q <= bus_wdata & CMD_KEEP;
   end

   hash_algo_e algo;
   hash_cmd_decode u_decode (
      .alg_bits ({cmd_q[10], cmd_q[6], cmd_q[5], cmd_q[4]}),
      .sg_bit   (cmd_q[CMD_SG]),
      .be_bit   (cmd_q[CMD_SHA_BE]),
      .le_bit   (cmd_q[CMD_MD5_LE]),
      .algo     (algo),
      .sg       (hash_sg),
      .sha_be   (hash_sha_be),
      .md5_le   (hash_md5_le)
   );
   assign hash_algo = algo;

   // ---------------- status word and interrupt ----------------
   logic [31:0] sts_word;
   always_comb begin
      sts_word                = '0;
      sts_word[STS_HASH_BUSY] = busy;
      sts_word[STS_HASH_IRQ]  = flag;
   end
   assign irq = |(sts_word & STS_IRQ_BITS);

   // ---------------- read path ----------------
   logic [31:0] rd_mux;
   logic        mapped;
   always_comb begin
      rd_mux = '0;
      mapped = 1'b0;
      if (hit_stat) begin rd_mux = sts_word; mapped = 1'b1; end
      if (hit_cmd)  begin rd_mux = cmd_q;    mapped = 1'b1; end
      for (int i = 0; i < NFLD; i++) begin
         if (bus_addr == OFS_W'(fld_ofs(i))) begin
            rd_mux = fld_q[i];
            mapped = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= rd_en;
         if (rd_en) bus_rdata <= rd_mux;
      end
   end

   // ---------------- assertions ----------------
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |=> (bus_rvalid && bus_rdata == 32'h0));   // R2
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> bus_rvalid);                                        // R2
   AST_DIGEST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (hash_dig_addr & LOW_DROP) == 32'h0);                         // R4
   AST_SRC_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (hash_src_addr & ~ADDR_KEEP) == 32'h0);                       // R3
   AST_LEN_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (hash_len & ~LEN_KEEP) == 32'h0);                             // R5
   AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> irq);                                         // R12

endmodule

// File: tb/hash_csr_frontend_tb.sv
module hash_csr_frontend_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, wen = 1'b0, done = 1'b0;
   logic [7:0]  addr = 8'h0;
   logic [31:0] wdata = 32'h0;

   logic        rvalid, start, irq, sg, be, le;
   logic [31:0] rdata, src_o, dig_o, key_o, len_o;
   logic [2:0]  algo_o;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;   // 125 MHz

   hash_csr_frontend u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_sel       (sel),
      .bus_wen       (wen),
      .bus_addr      (addr),
      .bus_wdata     (wdata),
      .bus_rvalid    (rvalid),
      .bus_rdata     (rdata),
      .hash_start    (start),
      .hash_done     (done),
      .hash_src_addr (src_o),
      .hash_dig_addr (dig_o),
      .hash_key_addr (key_o),
      .hash_len      (len_o),
      .hash_algo     (algo_o),
      .hash_sg       (sg),
      .hash_sha_be   (be),
      .hash_md5_le   (le),
      .irq           (irq)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [31:0] m_mode, m_src, m_dig, m_key, m_len, m_cmd, m_rdata;
   bit          m_busy, m_flag, m_start, m_rvalid;
   bit          was_busy, launch;

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h10:   return m_mode;
         8'h1C:   return (m_flag ? 32'h200 : 32'h0) | (m_busy ? 32'h1 : 32'h0);
         8'h20:   return m_src;
         8'h24:   return m_dig;
         8'h28:   return m_key;
         8'h2C:   return m_len;
         8'h30:   return m_cmd;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [2:0] m_algo(input logic [31:0] c);
      case (c & 32'h470)
         32'h000: return 3'd0;
         32'h020: return 3'd1;
         32'h040: return 3'd2;
         32'h050: return 3'd3;
         32'h460: return 3'd4;
         32'h060: return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_src = 0; m_dig = 0; m_key = 0; m_len = 0; m_cmd = 0;
         m_rdata = 0; m_busy = 0; m_flag = 0; m_start = 0; m_rvalid = 0;
      end else begin
         was_busy = m_busy;
         launch   = 0;
         m_rvalid = sel && !wen;
         if (sel && !wen) m_rdata = m_read(addr);
         if (sel && wen) begin
            case (addr)
               8'h10: m_mode = wdata;
               8'h20: m_src  = wdata & 32'h7FFF_FFFF;
               8'h24: m_dig  = wdata & 32'h7FFF_FFF8;
               8'h28: m_key  = wdata & 32'h7FFF_FFFF;
               8'h2C: m_len  = wdata & 32'h0FFF_FFFF;
               8'h30: if (!was_busy) begin
                         m_cmd = wdata & 32'h0004_047C;
                         launch = 1;
                         m_busy = 1;
                      end
               8'h1C: if (wdata[9]) m_flag = 0;
               default: ;
            endcase
         end
         if (done && was_busy) begin
            m_busy = 0;
            m_flag = 1;
         end
         m_start = launch;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(start == m_start, "R8 hash_start", {31'b0, start}, {31'b0, m_start});
         chk(irq == m_flag, "R12 irq", {31'b0, irq}, {31'b0, m_flag});
         chk(rvalid == m_rvalid, "R2 rvalid", {31'b0, rvalid}, {31'b0, m_rvalid});
         if (m_rvalid) chk(rdata == m_rdata, "R2 rdata", rdata, m_rdata);
         chk(src_o == m_src, "R3 src out", src_o, m_src);
         chk(key_o == m_key, "R3 key out", key_o, m_key);
         chk(dig_o == m_dig, "R4 digest out", dig_o, m_dig);
         chk(len_o == m_len, "R5 length out", len_o, m_len);
         chk(algo_o == m_algo(m_cmd), "R7 algo", {29'b0, algo_o}, {29'b0, m_algo(m_cmd)});
         chk({sg, be, le} == {m_cmd[18], m_cmd[3], m_cmd[2]}, "R6 options",
             {29'b0, sg, be, le}, {29'b0, m_cmd[18], m_cmd[3], m_cmd[2]});
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1; wen = 1; addr = a; wdata = d;
      @(negedge clk);
      sel = 0; wen = 0;
   endtask

   task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      sel = 1; wen = 0; addr = a;
      @(negedge clk);
      sel = 0;
      chk(rvalid == 1'b1, tag, {31'b0, rvalid}, 32'h1);
      chk(rdata == exp, tag, rdata, exp);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      done = 1;
      @(negedge clk);
      done = 0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      chk(irq == 0 && start == 0, "R1 outputs after reset", {30'b0, irq, start}, 32'h0);
      bus_read(8'h10, 32'h0, "R1 mode zero (direct addressing)");
      bus_read(8'h1C, 32'h0, "R1 status zero");
      bus_read(8'h20, 32'h0, "R1 source zero");
      bus_read(8'h24, 32'h0, "R1 digest zero");
      bus_read(8'h28, 32'h0, "R1 key zero");
      bus_read(8'h2C, 32'h0, "R1 length zero");
      bus_read(8'h30, 32'h0, "R1 command zero");

      // R2..R5 all-ones write masking
      bus_write(8'h10, 32'hFFFF_FFFF);
      bus_write(8'h20, 32'hFFFF_FFFF);
      bus_write(8'h24, 32'hFFFF_FFFF);
      bus_write(8'h28, 32'hFFFF_FFFF);
      bus_write(8'h2C, 32'hFFFF_FFFF);
      bus_read(8'h10, 32'hFFFF_FFFF, "R2 mode keeps all bits");
      bus_read(8'h20, 32'h7FFF_FFFF, "R3 source clipped");
      bus_read(8'h28, 32'h7FFF_FFFF, "R3 key clipped");
      bus_read(8'h24, 32'h7FFF_FFF8, "R4 digest clipped and aligned");
      bus_read(8'h2C, 32'h0FFF_FFFF, "R5 length clipped");
      bus_write(8'h24, 32'h1234_5677);
      bus_read(8'h24, 32'h1234_5670, "R4 digest low bits dropped");

      // R2 unmapped offset
      bus_write(8'h14, 32'hDEAD_BEEF);
      bus_read(8'h14, 32'h0, "R2 unmapped reads zero");
      bus_read(8'h20, 32'h7FFF_FFFF, "R2 unmapped write left source alone");

      // R8 launch
      bus_write(8'h30, 32'h0000_0058);
      chk(start == 1, "R8 start pulse after command", {31'b0, start}, 32'h1);
      @(negedge clk);
      chk(start == 0, "R8 start lasts one cycle", {31'b0, start}, 32'h0);
      chk(algo_o == 3'd3 && be == 1, "R7 SHA-256 decode", {28'b0, be, algo_o}, 32'hB);
      bus_read(8'h1C, 32'h1, "R8 busy set");

      // R9 command while busy
      bus_write(8'h30, 32'h0000_0020);
      chk(start == 0, "R9 no start while busy", {31'b0, start}, 32'h0);
      bus_read(8'h30, 32'h58, "R9 command unchanged");

      // R10 / R12 completion
      pulse_done();
      chk(irq == 1, "R12 irq on completion", {31'b0, irq}, 32'h1);
      bus_read(8'h1C, 32'h200, "R10 done sets flag, clears busy");
      pulse_done();
      bus_read(8'h1C, 32'h200, "R10 idle done ignored");

      // R11 clear
      bus_write(8'h1C, 32'hFFFF_FDFF);
      bus_read(8'h1C, 32'h200, "R11 write without bit 9 ignored");
      bus_write(8'h1C, 32'h200);
      bus_read(8'h1C, 32'h0, "R11 flag cleared");
      chk(irq == 0, "R12 irq drops after clear", {31'b0, irq}, 32'h0);

      // R6 / R7 decode table
      begin
         logic [31:0] cmds [8];
         logic [2:0]  exps [8];
         cmds[0] = 32'h0000_0004; exps[0] = 3'd0;
         cmds[1] = 32'h0000_0020; exps[1] = 3'd1;
         cmds[2] = 32'h0000_0040; exps[2] = 3'd2;
         cmds[3] = 32'h0004_0050; exps[3] = 3'd3;
         cmds[4] = 32'h0000_0460; exps[4] = 3'd4;
         cmds[5] = 32'h0004_0068; exps[5] = 3'd5;
         cmds[6] = 32'h0000_0010; exps[6] = 3'd7;
         cmds[7] = 32'hFFFF_FFFF; exps[7] = 3'd7;
         for (int i = 0; i < 8; i++) begin
            bus_write(8'h30, cmds[i]);
            chk(algo_o == exps[i], "R7 algorithm decode", {29'b0, algo_o}, {29'b0, exps[i]});
            chk(sg == cmds[i][18], "R6 list-mode bit", {31'b0, sg}, {31'b0, cmds[i][18]});
            pulse_done();
            bus_write(8'h1C, 32'h200);
         end
      end
      bus_read(8'h30, 32'h0004_047C, "R6 command keeps only defined bits");

      // R11 done and clear in the same cycle
      bus_write(8'h30, 32'h0000_0040);
      @(negedge clk);
      sel = 1; wen = 1; addr = 8'h1C; wdata = 32'h200; done = 1;
      @(negedge clk);
      sel = 0; wen = 0; done = 0;
      bus_read(8'h1C, 32'h200, "R11 set wins over clear");
      bus_write(8'h1C, 32'h200);

      // R9 / R10 command and done in the same cycle
      bus_write(8'h30, 32'h0000_0020);
      @(negedge clk);
      sel = 1; wen = 1; addr = 8'h30; wdata = 32'h0000_0040; done = 1;
      @(negedge clk);
      sel = 0; wen = 0; done = 0;
      chk(start == 0, "R9 command colliding with done not launched", {31'b0, start}, 32'h0);
      bus_read(8'h30, 32'h20, "R9 command kept");
      bus_read(8'h1C, 32'h200, "R10 done completes");

      repeat (3) @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end

endmodule